// File: doc/BRIEF.md
# Seeded State-Space Lock for a Symbol Sequence Detector

This block hides a small functional state machine inside a much larger state register, so that a fresh chip powers up locked. A two-bit functional machine, which detects the symbol pattern 1, 2, 3, sits in the low bits of an eight-bit state. Six extra lock bits sit above it. While reset is asserted, the whole eight-bit register loads a seed. The seed stands in for a value derived from the chip's own process variation. Any nonzero lock bits mean that the machine is outside the functional space.

While locked, every valid input symbol moves the state through a fixed mixing function: a one-bit left rotate followed by an XOR with a per-symbol key. The function is deterministic, so the owner of the design can compute, for each chip's seed, a symbol sequence that drives the lock bits to zero. That sequence differs from chip to chip. When the lock bits first become zero, the state lands on the detector's idle state. From then on, only the detector's transitions apply. Without the right sequence the chip stays locked indefinitely, and its detect output stays low.

Top module: `puf_lock_fsm`

## Requirements
- R1: A clock edge with `rst_n` low loads the full 8-bit state from `seed`. After that edge, `locked` is high exactly when `seed[7:2]` is nonzero.
- R2: `locked` is high exactly when state bits [7:2] are nonzero. While `locked` is high, `detect` is 0.
- R3: A clock edge with `rst_n` high and `sym_vld` low leaves the state unchanged, whatever the value of `sym`.
- R4: While locked, a valid symbol x moves the state to rotl1(state) XOR K[x], where K[0]=0x35, K[1]=0xA6, K[2]=0x5B and K[3]=0xC9, provided bits [7:2] of that result are nonzero.
- R5: If bits [7:2] of the R4 result are zero, the state becomes 0x00 (detector idle). `locked` therefore falls on exactly the edge that takes the last symbol of the unlock path.
- R6: Once `locked` is low, it stays low until the next reset load, whatever valid symbols follow.
- R7: When unlocked, the detector state follows these rules on each valid symbol s. If s=1, it goes to state 1. If the state is 1 and s=2, it goes to state 2. If the state is 2 and s=3, it goes to state 3. Any other symbol sends it to state 0. `detect` is high in state 3.
- R8: A seed with bits [7:2] zero starts unlocked, with the detector in state `seed[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the seed |
| seed | input | 8 | Chip-unique power-up state value |
| sym_vld | input | 1 | Qualifies `sym` for this cycle |
| sym | input | 2 | Input symbol |
| locked | output | 1 | High while the state is outside the functional space |
| detect | output | 1 | Pattern 1,2,3 seen (forced low while locked) |

## Verification
The hardest situation to reach from the ports is the exact edge on which the lock bits clear. A random symbol stream hits it only by chance, and it has to land on the last symbol of a chip-specific path. The bench searches the mixing function breadth-first from each seed to find the shortest unlock path. It then applies that path and checks `locked` on every edge, so the path never touches the functional space early. For the locked case, the bench builds sequences whose every step steers away from that space, and checks that many valid symbols still leave the block locked.

// File: rtl/puf_lock_fsm.sv
module puf_lock_fsm #(
  parameter int FUNC_W = 2,
  parameter int LOCK_W = 6,
  parameter logic [4*(FUNC_W+LOCK_W)-1:0] MIX_KEYS = 32'hC95BA635
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [FUNC_W+LOCK_W-1:0]   seed,
  input  logic                       sym_vld,
  input  logic [1:0]                 sym,
  output logic                       locked,
  output logic                       detect
);
  localparam int ST_W = FUNC_W + LOCK_W;
  localparam logic [ST_W-1:0]   INIT_CODE = '0;
  localparam logic [FUNC_W-1:0] F_IDLE = FUNC_W'(0);
  localparam logic [FUNC_W-1:0] F_A    = FUNC_W'(1);
  localparam logic [FUNC_W-1:0] F_B    = FUNC_W'(2);
  localparam logic [FUNC_W-1:0] F_HIT  = FUNC_W'(3);
  localparam logic [1:0] PAT0 = 2'd1;
  localparam logic [1:0] PAT1 = 2'd2;
  localparam logic [1:0] PAT2 = 2'd3;

  logic [ST_W-1:0]   state, mixed, mix_next;
  logic [FUNC_W-1:0] fst, fnext;

  assign fst      = state[FUNC_W-1:0];
  assign mixed    = {state[ST_W-2:0], state[ST_W-1]} ^ MIX_KEYS[ST_W*sym +: ST_W];
  assign mix_next = (mixed[ST_W-1:FUNC_W] == '0) ? INIT_CODE : mixed;

  always_comb begin
    if (sym == PAT0)                     fnext = F_A;
    else if (fst == F_A && sym == PAT1)  fnext = F_B;
    else if (fst == F_B && sym == PAT2)  fnext = F_HIT;
    else                                 fnext = F_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= seed;
    else if (sym_vld) state <= locked ? mix_next : {{LOCK_W{1'b0}}, fnext};
  end

  assign locked = |state[ST_W-1:FUNC_W];
  assign detect = !locked && (fst == F_HIT);
endmodule

module puf_lock_fsm_chk #(
  parameter int ST_W   = 8,
  parameter int FUNC_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sym_vld,
  input logic [1:0]      sym,
  input logic            locked,
  input logic            detect,
  input logic [ST_W-1:0] state
);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> $stable(state));

  // R6
  stay_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !locked);

  // R5
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(locked)) |-> (state == '0));

  // R4
  locked_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && sym_vld) |=> (locked || state == '0));

  // R7
  detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(detect)) |-> ($past(sym_vld) && $past(sym) == 2'd3));

  // R2
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state[ST_W-1:FUNC_W] != '0) |-> (locked && !detect));
endmodule

bind puf_lock_fsm puf_lock_fsm_chk #(.ST_W(ST_W), .FUNC_W(FUNC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym(sym),
  .locked(locked), .detect(detect), .state(state)
);

// File: tb/sim_puf_lock_fsm.sv
module sim_puf_lock_fsm;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] seed = 0;
  logic       sym_vld = 0;
  logic [1:0] sym = 0;
  logic       locked, detect;

  int nvec = 0, nfail = 0;
  int m = 0;
  int path[$];
  int keys[4] = '{8'h35, 8'hA6, 8'h5B, 8'hC9};

  always #5 clk = ~clk;

  puf_lock_fsm u0 (.clk(clk), .rst_n(rst_n), .seed(seed), .sym_vld(sym_vld),
                   .sym(sym), .locked(locked), .detect(detect));

  function automatic int mixraw(int s, int x);
    return (((s << 1) | (s >> 7)) & 255) ^ keys[x];
  endfunction

  function automatic int model_next(int s, int x);
    int t;
    if ((s >> 2) != 0) begin
      t = mixraw(s, x);
      return ((t >> 2) == 0) ? 0 : t;
    end
    if (x == 1) return 1;
    if ((s & 3) == 1 && x == 2) return 2;
    if ((s & 3) == 2 && x == 3) return 3;
    return 0;
  endfunction

  task automatic cmp(string tag);
    bit el, ed;
    el = (m >> 2) != 0;
    ed = !el && ((m & 3) == 3);
    nvec++;
    if (locked !== el || detect !== ed) begin
      nfail++;
      $display("FAIL %s: locked/detect actual %b/%b expected %b/%b (model state %02h)",
               tag, locked, detect, el, ed, m);
    end
  endtask

  task automatic do_reset(int s);
    @(negedge clk);
    rst_n = 0; seed = 8'(s); sym_vld = 0;
    @(posedge clk);
    m = s;
    #2 cmp("R1");
  endtask

  task automatic step(bit v, int x, string tag);
    @(negedge clk);
    rst_n = 1; sym_vld = v; sym = 2'(x);
    @(posedge clk);
    if (v) m = model_next(m, x);
    #2 cmp(tag);
  endtask

  task automatic bfs(int s0);
    int prv[256];
    int psym[256];
    bit seen[256];
    int q[$];
    int u, v, c;
    path.delete();
    foreach (seen[i]) seen[i] = 0;
    q.push_back(s0); seen[s0] = 1; prv[s0] = -1;
    while (q.size() > 0) begin
      u = q.pop_front();
      for (int x = 0; x < 4; x++) begin
        v = mixraw(u, x);
        if ((v >> 2) == 0) begin
          path.push_front(x);
          c = u;
          while (prv[c] >= 0) begin
            path.push_front(psym[c]);
            c = prv[c];
          end
          return;
        end
        if (!seen[v]) begin
          seen[v] = 1; prv[v] = u; psym[v] = x; q.push_back(v);
        end
      end
    end
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int seeds[6] = '{8'hB7, 8'h4C, 8'hE1, 8'h93, 8'h7F, 8'h2A};
    do_reset(8'hB7);
    for (int i = 0; i < 6; i++) step(0, i % 4, "R3");

    foreach (seeds[k]) begin
      do_reset(seeds[k]);
      bfs(seeds[k]);
      for (int i = 0; i < path.size(); i++) begin
        step(0, 3 - path[i], "R3");
        step(1, path[i], (i == path.size() - 1) ? "R5" : "R4");
      end
      nvec++;
      if (locked !== 1'b0) begin
        nfail++;
        $display("FAIL R5: locked after path actual %b expected 0", locked);
      end
      for (int i = 0; i < 8; i++) step(1, (i * 3 + k) % 4, "R6");
      step(1, 1, "R7"); step(0, 0, "R3"); step(1, 2, "R7"); step(1, 3, "R7");
      nvec++;
      if (detect !== 1'b1) begin
        nfail++;
        $display("FAIL R7: detect after 1,2,3 actual %b expected 1", detect);
      end
      step(1, 3, "R7");
    end

    for (int k = 0; k < 3; k++) begin
      do_reset(seeds[k]);
      for (int i = 0; i < 12; i++) begin
        int x;
        x = (i + k) % 4;
        for (int j = 0; j < 4; j++)
          if ((mixraw(m, (i + k + j) % 4) >> 2) != 0) begin x = (i + k + j) % 4; break; end
        step(1, x, "R4");
      end
      nvec++;
      if (locked !== 1'b1 || detect !== 1'b0) begin
        nfail++;
        $display("FAIL R2: wrong sequence locked/detect actual %b/%b expected 1/0", locked, detect);
      end
    end

    do_reset(8'h02);
    step(1, 3, "R8");
    do_reset(8'h03);
    step(0, 0, "R8");
    step(1, 0, "R7");
    step(1, 1, "R7"); step(1, 2, "R7"); step(1, 2, "R7");
    step(1, 1, "R7"); step(1, 1, "R7"); step(1, 2, "R7"); step(1, 3, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule